// File: doc/BRIEF.md
# Indexed Pixel Scanline Palette Converter

This block turns one scanline of 8-bit indexed pixels into a byte stream of true-colour output. A line is started with a one-cycle `start` pulse. The pulse carries three things: the line number, the active width in pixels and an output depth setting. The block reads the line's pixels one at a time from a byte-addressed video memory. Line starts are a fixed 1024 bytes apart, whatever the width. Each pixel byte is looked up in an external palette that returns separate red, green and blue values. The result leaves on an 8-bit valid/ready stream, and `out_last` marks the final byte of the line.

Three packings are offered:
- **32-bit:** blue, green, red and a zero pad byte per pixel.
- **24-bit:** blue, green and red per pixel.
- **8-bit:** the index byte is copied straight through, and no palette read is made.

A depth of zero blocks the line entirely. Both the video memory and the palette have a registered read port with one cycle of latency. The block holds the captured values in its own registers, so a stalled output never needs a second read.

Top module: `pal_line_conv`

## Requirements
- R1: Pixel x of line L is read from byte address L*1024 + x, for x = 0 to width-1 in increasing order. The address does not depend on the width. The line number occupies address bits [19:10] and x occupies bits [9:0].
- R2: With depth 32, each pixel emits four bytes: palette blue, palette green, palette red, then 0x00.
- R3: With depth 24, each pixel emits three bytes: palette blue, palette green, palette red, with no pad byte.
- R4: With depth 8, or any non-zero depth other than 24 and 32, each pixel emits its index byte unchanged. `pal_rd` stays low for the whole line.
- R5: A `start` with depth 0 is ignored. `busy`, `out_valid` and `vm_rd` stay low.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` keeps its value in the next cycle.
- R7: `out_last` is high on exactly one byte of a line, the final byte of its last pixel. In the cycle after that byte is accepted, `busy` is low.
- R8: Out of reset, `busy`, `out_valid`, `vm_rd` and `pal_rd` are low.
- R9: A `start` while `busy` is high is ignored. The running line completes with its original line, width and depth, and no extra bytes follow it.
- R10: A `start` with width 0 is ignored in the same way as depth 0. Widths from 1 to 1024 are converted in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin converting one scanline |
| line_sel | input | 10 | Scanline number |
| width | input | 11 | Active pixels in the line (1 to 1024) |
| depth | input | 8 | Output depth: 32, 24, other non-zero = 8-bit, 0 = off |
| busy | output | 1 | A line is being converted |
| vm_rd | output | 1 | Video memory read strobe |
| vm_addr | output | 20 | Video memory byte address |
| vm_data | input | 8 | Video memory data, one cycle after vm_rd |
| pal_rd | output | 1 | Palette read strobe |
| pal_idx | output | 8 | Palette index |
| pal_r | input | 8 | Palette red, one cycle after pal_rd |
| pal_g | input | 8 | Palette green, one cycle after pal_rd |
| pal_b | input | 8 | Palette blue, one cycle after pal_rd |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Final byte of the line |
| out_ready | input | 1 | Downstream accepts the byte |

## Verification
Two situations are hard to reach from the ports. The first is a stall that lands on the pad byte or on the final byte of a line, because the pixel counter must not advance until that byte is accepted. The second is a `start` that arrives in the middle of a line. The stimulus drives `out_ready` from a pseudo-random pattern across full-width lines, so stalls fall on every byte position, including the `out_last` byte. It also pulses `start` with different parameters partway through a running line and checks that the stream keeps the original line's content and length. A width-1024 line at the bottom line number exercises the widest address, and the memory model hashes every address bit into the data, so a wrong stride or pixel order shows up as wrong bytes.

// File: rtl/plc_pkg.sv
package plc_pkg;

  typedef enum logic [1:0] {
    MODE_PASS  = 2'd0,
    MODE_RGB24 = 2'd1,
    MODE_RGB32 = 2'd2
  } pix_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_FETCH = 3'd1,
    ST_LOOK  = 3'd2,
    ST_CAP   = 3'd3,
    ST_EMIT  = 3'd4
  } seq_st_e;

  // depth code to packing; anything not 24 or 32 falls back to passthrough
  function automatic pix_mode_e decode_depth(input logic [7:0] d);
    if (d == 8'd32)      return MODE_RGB32;
    else if (d == 8'd24) return MODE_RGB24;
    else                 return MODE_PASS;
  endfunction

  // index of the final byte emitted for one pixel
  function automatic logic [1:0] final_byte_of(input pix_mode_e m);
    case (m)
      MODE_RGB32: return 2'd3;
      MODE_RGB24: return 2'd2;
      default:    return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/plc_addr_gen.sv
module plc_addr_gen #(
  parameter int LINE_W = 10,
  parameter int X_W    = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic                    step,
  input  logic                    fetch,
  input  logic [LINE_W-1:0]       line_in,
  input  logic [X_W:0]            width_in,
  output logic                    vm_rd,
  output logic [LINE_W+X_W-1:0]   vm_addr,
  output logic                    at_last
);
  localparam int ADDR_W = LINE_W + X_W;

  logic [LINE_W-1:0] line_q;
  logic [X_W-1:0]    x_q;
  logic [X_W:0]      width_q;

  // stride is 2**X_W bytes regardless of the active width
  function automatic logic [ADDR_W-1:0] calc_addr(input logic [LINE_W-1:0] ln,
                                                   input logic [X_W-1:0] x);
    return (ADDR_W'(ln) << X_W) | ADDR_W'(x);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q  <= '0;
      x_q     <= '0;
      width_q <= '0;
    end else if (load) begin
      line_q  <= line_in;
      x_q     <= '0;
      width_q <= width_in;
    end else if (step) begin
      x_q <= x_q + 1'b1;
    end
  end

  assign vm_rd   = fetch;
  assign vm_addr = calc_addr(line_q, x_q);
  assign at_last = ({1'b0, x_q} == (width_q - 1'b1));

  p_addr_in_width_r1: assert property (@(posedge clk) disable iff (!rst_n)
    vm_rd |-> ({1'b0, vm_addr[X_W-1:0]} < width_q));

endmodule

// File: rtl/plc_lookup.sv
module plc_lookup #(
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             look,
  input  logic             cap,
  input  logic             use_pal,
  input  logic [PIX_W-1:0] vm_data,
  output logic             pal_rd,
  output logic [PIX_W-1:0] pal_idx,
  input  logic [PIX_W-1:0] pal_r,
  input  logic [PIX_W-1:0] pal_g,
  input  logic [PIX_W-1:0] pal_b,
  output logic [PIX_W-1:0] idx_q,
  output logic [PIX_W-1:0] r_q,
  output logic [PIX_W-1:0] g_q,
  output logic [PIX_W-1:0] b_q
);
  assign pal_rd  = look && use_pal;
  assign pal_idx = vm_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= '0;
      r_q   <= '0;
      g_q   <= '0;
      b_q   <= '0;
    end else begin
      if (look) idx_q <= vm_data;
      if (cap) begin
        r_q <= pal_r;
        g_q <= pal_g;
        b_q <= pal_b;
      end
    end
  end

  // colour capture only ever takes data requested in the previous cycle (R2, R3)
  p_cap_after_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cap |-> $past(pal_rd));

endmodule

// File: rtl/plc_packer.sv
module plc_packer
  import plc_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             emit,
  input  pix_mode_e        mode,
  input  logic [PIX_W-1:0] idx,
  input  logic [PIX_W-1:0] r,
  input  logic [PIX_W-1:0] g,
  input  logic [PIX_W-1:0] b,
  input  logic             at_last,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [PIX_W-1:0] out_data,
  output logic             out_last,
  output logic             pix_done
);
  logic [1:0] byte_q;
  logic       fire;
  logic       final_byte;

  // byte order within a pixel: blue, green, red, then a zero pad
  function automatic logic [PIX_W-1:0] pick_byte(input pix_mode_e m, input logic [1:0] sel,
                                                 input logic [PIX_W-1:0] ix,
                                                 input logic [PIX_W-1:0] rr,
                                                 input logic [PIX_W-1:0] gg,
                                                 input logic [PIX_W-1:0] bb);
    if (m == MODE_PASS) return ix;
    case (sel)
      2'd0:    return bb;
      2'd1:    return gg;
      2'd2:    return rr;
      default: return '0;
    endcase
  endfunction

  assign out_valid  = emit;
  assign fire       = emit && out_ready;
  assign final_byte = (byte_q == final_byte_of(mode));
  assign pix_done   = fire && final_byte;
  assign out_last   = emit && final_byte && at_last;
  assign out_data   = pick_byte(mode, byte_q, idx, r, g, b);

  always_ff @(posedge clk) begin
    if (!rst_n)        byte_q <= '0;
    else if (pix_done) byte_q <= '0;
    else if (fire)     byte_q <= byte_q + 1'b1;
  end

  p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

endmodule

// File: rtl/plc_seq.sv
module plc_seq
  import plc_pkg::*;
#(
  parameter int WID_W   = 11,
  parameter int DEPTH_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [DEPTH_W-1:0] depth,
  input  logic [WID_W-1:0]   width,
  input  logic               pix_done,
  input  logic               at_last,
  output seq_st_e            st,
  output pix_mode_e          mode_q,
  output logic               load,
  output logic               step
);
  seq_st_e st_n;

  assign load = (st == ST_IDLE) && start && (depth != '0) && (width != '0);
  assign step = pix_done && !at_last;

  always_comb begin
    st_n = st;
    case (st)
      ST_IDLE:  if (load) st_n = ST_FETCH;
      ST_FETCH: st_n = ST_LOOK;
      ST_LOOK:  st_n = (mode_q == MODE_PASS) ? ST_EMIT : ST_CAP;
      ST_CAP:   st_n = ST_EMIT;
      ST_EMIT:  if (pix_done) st_n = at_last ? ST_IDLE : ST_FETCH;
      default:  st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      mode_q <= MODE_PASS;
    end else begin
      st <= st_n;
      if (load) mode_q <= decode_depth(8'(depth));
    end
  end

endmodule

// File: rtl/pal_line_conv.sv
module pal_line_conv
  import plc_pkg::*;
#(
  parameter int LINE_W  = 10,
  parameter int X_W     = 10,
  parameter int PIX_W   = 8,
  parameter int DEPTH_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [LINE_W-1:0]     line_sel,
  input  logic [X_W:0]          width,
  input  logic [DEPTH_W-1:0]    depth,
  output logic                  busy,
  output logic                  vm_rd,
  output logic [LINE_W+X_W-1:0] vm_addr,
  input  logic [PIX_W-1:0]      vm_data,
  output logic                  pal_rd,
  output logic [PIX_W-1:0]      pal_idx,
  input  logic [PIX_W-1:0]      pal_r,
  input  logic [PIX_W-1:0]      pal_g,
  input  logic [PIX_W-1:0]      pal_b,
  output logic                  out_valid,
  output logic [PIX_W-1:0]      out_data,
  output logic                  out_last,
  input  logic                  out_ready
);
  localparam int WID_W = X_W + 1;

  seq_st_e    st;
  pix_mode_e  mode_q;
  logic       load, step, pix_done, at_last;
  logic       fetch_ev, look_ev, cap_ev, emit_ev;
  logic [PIX_W-1:0] idx_q, r_q, g_q, b_q;

  assign fetch_ev = (st == ST_FETCH);
  assign look_ev  = (st == ST_LOOK);
  assign cap_ev   = (st == ST_CAP);
  assign emit_ev  = (st == ST_EMIT);
  assign busy     = (st != ST_IDLE);

  plc_seq #(.WID_W(WID_W), .DEPTH_W(DEPTH_W)) u_seq (
    .clk, .rst_n, .start, .depth, .width,
    .pix_done, .at_last, .st, .mode_q, .load, .step
  );

  plc_addr_gen #(.LINE_W(LINE_W), .X_W(X_W)) u_addr (
    .clk, .rst_n, .load, .step, .fetch(fetch_ev),
    .line_in(line_sel), .width_in(width),
    .vm_rd, .vm_addr, .at_last
  );

  plc_lookup #(.PIX_W(PIX_W)) u_lookup (
    .clk, .rst_n, .look(look_ev), .cap(cap_ev),
    .use_pal(mode_q != MODE_PASS), .vm_data,
    .pal_rd, .pal_idx, .pal_r, .pal_g, .pal_b,
    .idx_q, .r_q, .g_q, .b_q
  );

  plc_packer #(.PIX_W(PIX_W)) u_pack (
    .clk, .rst_n, .emit(emit_ev), .mode(mode_q),
    .idx(idx_q), .r(r_q), .g(g_q), .b(b_q),
    .at_last, .out_ready,
    .out_valid, .out_data, .out_last, .pix_done
  );

  p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!out_valid && !vm_rd && !pal_rd));

  p_last_ends_line_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_last && out_ready) |=> !busy);

  p_pass_skips_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (look_ev && mode_q == MODE_PASS) |=> emit_ev);

  p_busy_ignores_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(mode_q));

endmodule

// File: tb/pal_line_conv_tb_top.sv
module pal_line_conv_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [9:0]  line_sel = '0;
  logic [10:0] width = '0;
  logic [7:0]  depth = '0;
  logic        busy, vm_rd, pal_rd, out_valid, out_last;
  logic [19:0] vm_addr;
  logic [7:0]  vm_data = '0;
  logic [7:0]  pal_idx, out_data;
  logic [7:0]  pal_r = '0, pal_g = '0, pal_b = '0;
  logic        out_ready = 1'b1;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic [8:0] exp_q[$];
  string      cur_req = "R2";
  bit         cur_pass = 1'b0;
  bit         rnd_ready = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  bit         hold_v = 1'b0;
  logic [7:0] hold_d = '0;

  always #2 clk = ~clk;

  pal_line_conv dut_i (
    .clk, .rst_n, .start, .line_sel, .width, .depth, .busy,
    .vm_rd, .vm_addr, .vm_data, .pal_rd, .pal_idx,
    .pal_r, .pal_g, .pal_b,
    .out_valid, .out_data, .out_last, .out_ready
  );

  function automatic logic [7:0] mem_f(input logic [19:0] a);
    return (a[7:0] + a[17:10] * 8'd7) ^ {a[9:8], a[19:18], 4'h5};
  endfunction
  function automatic logic [7:0] red_f(input logic [7:0] i);   return i ^ 8'hA5; endfunction
  function automatic logic [7:0] green_f(input logic [7:0] i); return i * 8'd3 + 8'd1; endfunction
  function automatic logic [7:0] blue_f(input logic [7:0] i);  return ~i; endfunction

  // memory and palette models with one cycle of read latency
  always @(posedge clk) begin
    if (vm_rd) vm_data <= mem_f(vm_addr);
    if (pal_rd) begin
      pal_r <= red_f(pal_idx);
      pal_g <= green_f(pal_idx);
      pal_b <= blue_f(pal_idx);
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      finish_run();
    end
  end

  // monitor: sets ready for the coming edge, then scores that edge's handshake
  always @(negedge clk) begin
    if (rst_n) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready = rnd_ready ? (lfsr[0] | lfsr[3]) : 1'b1;
      if (hold_v) begin
        chk(out_valid == 1'b1, "R6 valid held", out_valid, 1);
        chk(out_data == hold_d, "R6 data held", out_data, hold_d);
      end
      if (cur_pass && pal_rd) chk(1'b0, "R4 palette read in passthrough", pal_rd, 0);
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, {cur_req, " unexpected byte"}, out_data, 0);
        end else begin
          logic [8:0] e;
          e = exp_q.pop_front();
          chk(out_data == e[7:0], {cur_req, " data"}, out_data, e[7:0]);
          chk(out_last == e[8], "R7 last flag", out_last, e[8]);
        end
      end
      hold_v = out_valid && !out_ready;
      hold_d = out_data;
    end
  end

  task automatic build_expect(input int dp, input int w, input int ln);
    for (int x = 0; x < w; x++) begin
      logic [19:0] a;
      logic [7:0]  i;
      bit          lst;
      a   = {ln[9:0], x[9:0]};
      i   = mem_f(a);
      lst = (x == w - 1);
      if (dp == 32) begin
        exp_q.push_back({1'b0, blue_f(i)});
        exp_q.push_back({1'b0, green_f(i)});
        exp_q.push_back({1'b0, red_f(i)});
        exp_q.push_back({lst, 8'h00});
      end else if (dp == 24) begin
        exp_q.push_back({1'b0, blue_f(i)});
        exp_q.push_back({1'b0, green_f(i)});
        exp_q.push_back({lst, red_f(i)});
      end else begin
        exp_q.push_back({lst, i});
      end
    end
  endtask

  task automatic pulse_start(input int dp, input int w, input int ln);
    @(negedge clk);
    start = 1'b1; depth = dp[7:0]; width = w[10:0]; line_sel = ln[9:0];
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_line(input int dp, input int w, input int ln, input bit rnd,
                          input string req, input bit interfere);
    cur_req   = req;
    cur_pass  = !(dp == 24 || dp == 32);
    rnd_ready = rnd;
    build_expect(dp, w, ln);
    pulse_start(dp, w, ln);
    chk(busy == 1'b1, {req, " line started"}, busy, 1);
    if (interfere) begin
      repeat (25) @(negedge clk);
      pulse_start(32, 7, 9);   // R9: must be ignored
    end
    while (busy) @(negedge clk);
    chk(exp_q.size() == 0, {req, " bytes left over"}, exp_q.size(), 0);
    repeat (6) @(negedge clk);
    chk(exp_q.size() == 0 && !out_valid, {req, " quiet after line"}, out_valid, 0);
    exp_q.delete();
  endtask

  task automatic blocked_start(input int dp, input int w, input string req);
    int act = 0;
    cur_req = req;
    pulse_start(dp, w, 4);
    repeat (40) begin
      @(negedge clk);
      if (busy || out_valid || vm_rd) act++;
    end
    chk(act == 0, {req, " start ignored"}, act, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !out_valid && !vm_rd && !pal_rd, "R8 reset outputs", busy, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !out_valid && !vm_rd && !pal_rd, "R8 after reset", out_valid, 0);

    run_line(32, 5, 3, 1'b0, "R2", 1'b0);
    run_line(32, 9, 100, 1'b1, "R2", 1'b0);
    run_line(24, 6, 767, 1'b1, "R3", 1'b0);
    run_line(8, 4, 12, 1'b1, "R4", 1'b0);
    run_line(16, 3, 513, 1'b0, "R4", 1'b0);
    run_line(255, 2, 1, 1'b1, "R4", 1'b0);
    blocked_start(0, 10, "R5");
    blocked_start(24, 0, "R10");
    run_line(24, 1, 2, 1'b1, "R10", 1'b0);
    run_line(24, 1024, 767, 1'b1, "R1", 1'b0);
    run_line(32, 20, 55, 1'b1, "R9", 1'b1);
    run_line(8, 1024, 0, 1'b1, "R1", 1'b0);

    finish_run();
  end

endmodule